// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block is the control core that decides where a clock synthesizer takes its operating frequency from. Five strap pins are captured once, on the first clock after reset. A small register file holds a manual ratio code, an override bit, a programmable-enable bit, programmable N and M dividers, recovery N and M dividers, a recovery-source bit and a watchdog-enable bit. From these the block produces the active 5-bit ratio code, the active N and M values, a flag that says whether the synthesizer runs from N/M or from its table, and a one-clock frequency-change event.

The priority runs in three tiers. The straps are the default. The register code replaces them when override is set. Valid N/M settings replace both when programmable mode is on, and the override bit then only chooses which code sets the ratio. A watchdog time-out forces a recovery source and locks the frequency registers against bus writes until software clears the watchdog-enable bit. The behaviour is organised as a state machine:

- ST_CAPTURE: reset state. It latches the straps on the first clock and then leaves.
- ST_STRAP and ST_SEL: the two table states.
- ST_PROG: the programmable state.
- ST_RECOV: the locked recovery state.

Transitions:

- T_BOOT: ST_CAPTURE to the run state.
- T_RUN: moves among ST_STRAP, ST_SEL and ST_PROG as the registers change.
- T_TRIP: a run state to ST_RECOV on a time-out while the watchdog is enabled.
- T_RELEASE: ST_RECOV to the run state once watchdog-enable is 0.

Top module: `freq_src_sel`

## Requirements
- R1: With programmable mode off, the active code is the latched strap value when override (control bit 0) is 0, and the register code (index 1) when override is 1.
- R2: With programmable mode on (control bit 1) and N > M, prog_mode is 1, act_n and act_m equal the programmable N (index 2) and M (index 3), and the active code is the register code if override is 1, else the straps.
- R3: With programmable mode on and N <= M (so (N+3)/(M+3) <= 1), bad_ratio is 1 and the block stays on the table selection that override chooses.
- R4: Whenever prog_mode is 0, act_n and act_m are 0.
- R5: A wd_timeout pulse while watchdog-enable (control bit 3) is 1 enters recovery, and locked becomes 1. With the recovery-select bit (control bit 2) at 1, act_n and act_m come from the recovery registers (index 4 and 5) and prog_mode is 1. With it at 0, the code is the straps and prog_mode is 0.
- R6: While locked, bus writes to every register are ignored, except that a write to the control register still updates bit 3. Clearing bit 3 leaves recovery on the following clock.
- R7: A wd_timeout while watchdog-enable is 0 has no effect.
- R8: freq_chg is high for one clock when the active code, N, M or mode value changes, or when an accepted write to the register code, N or M landed on the previous clock. It stays low while locked and on the strap-capture clock.
- R9: The straps are captured on the first clock after reset. Later strap changes have no effect. The captured value reads back, read-only, at index 6.
- R10: Reset clears all registers and outputs, and the block starts in the capture state.
- R11: Index 7 reads status: bits 1:0 give the mode (0 straps, 1 register code, 2 programmable, 3 recovery), bit 6 gives locked and bit 7 gives bad_ratio. Index 0 reads the control bits 3:0.
- R12: A register write is reflected on the active outputs at the clock edge after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in | input | 5 | Strap pins, captured once after reset |
| wd_timeout | input | 1 | Watchdog time-out request |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 8 | Read data (combinational) |
| act_code | output | 5 | Active ratio/table code |
| act_n | output | 8 | Active N divider |
| act_m | output | 7 | Active M divider |
| prog_mode | output | 1 | 1 when N/M drive the frequency |
| freq_chg | output | 1 | One-clock frequency-change event |
| bad_ratio | output | 1 | Programmable setting rejected |
| locked | output | 1 | Recovery lock is active |

## Verification
On every cycle, the assertions check four properties:

- No change event is raised while locked.
- Locked registers stay stable.
- The captured straps never move after the capture clock.
- Programmable outputs always have N above M outside recovery, and the table modes drive zero dividers.

Only the bench scenarios can show that the right source wins for each mix of override, programmable and recovery bits. The same holds for a rewrite of an unchanged divider raising an event, for the lock releasing exactly when watchdog-enable is cleared, and for a time-out with the watchdog disabled being dropped.

// File: rtl/fss_pkg.sv
package fss_pkg;

    typedef enum logic [2:0] {
        ST_CAPTURE,
        ST_STRAP,
        ST_SEL,
        ST_PROG,
        ST_RECOV
    } fss_state_e;

    // register indices
    localparam int REG_CTRL  = 0;
    localparam int REG_SEL   = 1;
    localparam int REG_PN    = 2;
    localparam int REG_PM    = 3;
    localparam int REG_RN    = 4;
    localparam int REG_RM    = 5;
    localparam int REG_STRAP = 6;
    localparam int REG_STAT  = 7;

    // control register bit positions
    localparam int CTL_OVR  = 0;
    localparam int CTL_PROG = 1;
    localparam int CTL_RSEL = 2;
    localparam int CTL_WDEN = 3;

    // read-back mode codes
    localparam logic [1:0] MODE_STRAP = 2'd0;
    localparam logic [1:0] MODE_SEL   = 2'd1;
    localparam logic [1:0] MODE_PROG  = 2'd2;
    localparam logic [1:0] MODE_RECOV = 2'd3;

endpackage

// File: rtl/fss_strap_latch.sv
module fss_strap_latch #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] strap_in,
    output logic [CODE_W-1:0] strap_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q <= '0;
        end else if (capture) begin
            strap_q <= strap_in;
        end
    end

    // R9
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(strap_q));

endmodule

// File: rtl/fss_regs.sv
module fss_regs
    import fss_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int N_W    = 8,
    parameter int M_W    = 7,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              locked,
    output logic              cfg_override,
    output logic              cfg_prog_en,
    output logic              cfg_recov_sel,
    output logic              cfg_wd_en,
    output logic [CODE_W-1:0] sel_q,
    output logic [N_W-1:0]    pn_q,
    output logic [M_W-1:0]    pm_q,
    output logic [N_W-1:0]    rn_q,
    output logic [M_W-1:0]    rm_q,
    output logic              freq_wr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_override  <= 1'b0;
            cfg_prog_en   <= 1'b0;
            cfg_recov_sel <= 1'b0;
            cfg_wd_en     <= 1'b0;
            sel_q         <= '0;
            pn_q          <= '0;
            pm_q          <= '0;
            rn_q          <= '0;
            rm_q          <= '0;
            freq_wr       <= 1'b0;
        end else begin
            freq_wr <= 1'b0;
            if (wr_en) begin
                if (locked) begin
                    if (wr_idx == IDX_W'(REG_CTRL)) begin
                        cfg_wd_en <= wr_data[CTL_WDEN];
                    end
                end else begin
                    case (wr_idx)
                        IDX_W'(REG_CTRL): begin
                            cfg_override  <= wr_data[CTL_OVR];
                            cfg_prog_en   <= wr_data[CTL_PROG];
                            cfg_recov_sel <= wr_data[CTL_RSEL];
                            cfg_wd_en     <= wr_data[CTL_WDEN];
                        end
                        IDX_W'(REG_SEL): begin
                            sel_q   <= wr_data[CODE_W-1:0];
                            freq_wr <= 1'b1;
                        end
                        IDX_W'(REG_PN): begin
                            pn_q    <= wr_data[N_W-1:0];
                            freq_wr <= 1'b1;
                        end
                        IDX_W'(REG_PM): begin
                            pm_q    <= wr_data[M_W-1:0];
                            freq_wr <= 1'b1;
                        end
                        IDX_W'(REG_RN): rn_q <= wr_data[N_W-1:0];
                        IDX_W'(REG_RM): rm_q <= wr_data[M_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // R6
    lock_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(sel_q) && $stable(pn_q) && $stable(pm_q));

    // R6
    lock_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(rn_q) && $stable(rm_q) && $stable(cfg_prog_en) && $stable(cfg_override));

    // R8
    lock_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !freq_wr);

endmodule

// File: rtl/fss_fsm.sv
module fss_fsm
    import fss_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int N_W    = 8,
    parameter int M_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_timeout,
    input  logic              cfg_override,
    input  logic              cfg_prog_en,
    input  logic              cfg_recov_sel,
    input  logic              cfg_wd_en,
    input  logic [CODE_W-1:0] strap_src,
    input  logic [CODE_W-1:0] sel_q,
    input  logic [N_W-1:0]    pn_q,
    input  logic [M_W-1:0]    pm_q,
    input  logic [N_W-1:0]    rn_q,
    input  logic [M_W-1:0]    rm_q,
    input  logic              freq_wr,
    output fss_state_e        state,
    output logic [CODE_W-1:0] act_code,
    output logic [N_W-1:0]    act_n,
    output logic [M_W-1:0]    act_m,
    output logic              prog_mode,
    output logic              freq_chg,
    output logic              bad_ratio
);

    localparam int RW = ((N_W > M_W) ? N_W : M_W) + 1;

    fss_state_e        nxt;
    logic              prog_ok;
    fss_state_e        run_state;
    logic [CODE_W-1:0] ratio_code;
    logic [CODE_W-1:0] code_d;
    logic [N_W-1:0]    n_d;
    logic [M_W-1:0]    m_d;
    logic              prog_d;
    logic              bad_d;
    logic              differ;
    logic              chg_d;

    assign prog_ok    = RW'(pn_q) > RW'(pm_q);
    assign run_state  = (cfg_prog_en && prog_ok) ? ST_PROG
                      : (cfg_override ? ST_SEL : ST_STRAP);
    assign ratio_code = cfg_override ? sel_q : strap_src;

    // next state
    always_comb begin
        nxt = ST_CAPTURE;
        unique case (state)
            ST_CAPTURE: nxt = run_state;
            ST_STRAP, ST_SEL, ST_PROG:
                nxt = (wd_timeout && cfg_wd_en) ? ST_RECOV : run_state;
            ST_RECOV:   nxt = cfg_wd_en ? ST_RECOV : run_state;
            default:    nxt = ST_CAPTURE;
        endcase
    end

    // next outputs, decoded from the state being entered
    always_comb begin
        code_d = '0;
        n_d    = '0;
        m_d    = '0;
        prog_d = 1'b0;
        unique case (nxt)
            ST_CAPTURE: ;
            ST_STRAP:   code_d = strap_src;
            ST_SEL:     code_d = sel_q;
            ST_PROG: begin
                code_d = ratio_code;
                n_d    = pn_q;
                m_d    = pm_q;
                prog_d = 1'b1;
            end
            ST_RECOV: begin
                if (cfg_recov_sel) begin
                    code_d = ratio_code;
                    n_d    = rn_q;
                    m_d    = rm_q;
                    prog_d = 1'b1;
                end else begin
                    code_d = strap_src;
                end
            end
            default: ;
        endcase
        bad_d  = (nxt != ST_RECOV) && cfg_prog_en && !prog_ok;
        differ = (code_d != act_code) || (n_d != act_n) || (m_d != act_m)
               || (prog_d != prog_mode);
        chg_d  = (state != ST_CAPTURE) && (nxt != ST_RECOV) && (differ || freq_wr);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CAPTURE;
        end else begin
            state <= nxt;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_code  <= '0;
            act_n     <= '0;
            act_m     <= '0;
            prog_mode <= 1'b0;
            freq_chg  <= 1'b0;
            bad_ratio <= 1'b0;
        end else begin
            act_code  <= code_d;
            act_n     <= n_d;
            act_m     <= m_d;
            prog_mode <= prog_d;
            freq_chg  <= chg_d;
            bad_ratio <= bad_d;
        end
    end

    // R8
    locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOV) |-> !freq_chg);

    // R2
    prog_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && state != ST_RECOV) |-> (RW'(act_n) > RW'(act_m)));

    // R4
    table_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |-> (act_n == '0 && act_m == '0));

    // R3
    bad_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_ratio |-> !prog_mode);

    // R5
    recov_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STRAP || state == ST_SEL || state == ST_PROG) && wd_timeout && cfg_wd_en)
        |=> (state == ST_RECOV));

    // R6
    recov_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOV && !cfg_wd_en) |=> (state != ST_RECOV));

endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
    import fss_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int N_W    = 8,
    parameter int M_W    = 7,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] strap_in,
    input  logic              wd_timeout,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [CODE_W-1:0] act_code,
    output logic [N_W-1:0]    act_n,
    output logic [M_W-1:0]    act_m,
    output logic              prog_mode,
    output logic              freq_chg,
    output logic              bad_ratio,
    output logic              locked
);

    fss_state_e        state;
    logic              capture;
    logic [CODE_W-1:0] strap_q;
    logic [CODE_W-1:0] strap_src;
    logic              cfg_override, cfg_prog_en, cfg_recov_sel, cfg_wd_en;
    logic [CODE_W-1:0] sel_q;
    logic [N_W-1:0]    pn_q, rn_q;
    logic [M_W-1:0]    pm_q, rm_q;
    logic              freq_wr;
    logic [1:0]        mode;

    assign capture   = (state == ST_CAPTURE);
    assign locked    = (state == ST_RECOV);
    assign strap_src = capture ? strap_in : strap_q;

    fss_strap_latch #(.CODE_W(CODE_W)) u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .strap_in (strap_in),
        .strap_q  (strap_q)
    );

    fss_regs #(
        .CODE_W(CODE_W), .N_W(N_W), .M_W(M_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .locked        (locked),
        .cfg_override  (cfg_override),
        .cfg_prog_en   (cfg_prog_en),
        .cfg_recov_sel (cfg_recov_sel),
        .cfg_wd_en     (cfg_wd_en),
        .sel_q         (sel_q),
        .pn_q          (pn_q),
        .pm_q          (pm_q),
        .rn_q          (rn_q),
        .rm_q          (rm_q),
        .freq_wr       (freq_wr)
    );

    fss_fsm #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wd_timeout    (wd_timeout),
        .cfg_override  (cfg_override),
        .cfg_prog_en   (cfg_prog_en),
        .cfg_recov_sel (cfg_recov_sel),
        .cfg_wd_en     (cfg_wd_en),
        .strap_src     (strap_src),
        .sel_q         (sel_q),
        .pn_q          (pn_q),
        .pm_q          (pm_q),
        .rn_q          (rn_q),
        .rm_q          (rm_q),
        .freq_wr       (freq_wr),
        .state         (state),
        .act_code      (act_code),
        .act_n         (act_n),
        .act_m         (act_m),
        .prog_mode     (prog_mode),
        .freq_chg      (freq_chg),
        .bad_ratio     (bad_ratio)
    );

    always_comb begin
        unique case (state)
            ST_SEL:   mode = MODE_SEL;
            ST_PROG:  mode = MODE_PROG;
            ST_RECOV: mode = MODE_RECOV;
            default:  mode = MODE_STRAP;
        endcase
    end

    // software read-back
    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IDX_W'(REG_CTRL): begin
                rd_data[CTL_OVR]  = cfg_override;
                rd_data[CTL_PROG] = cfg_prog_en;
                rd_data[CTL_RSEL] = cfg_recov_sel;
                rd_data[CTL_WDEN] = cfg_wd_en;
            end
            IDX_W'(REG_SEL):   rd_data = DATA_W'(sel_q);
            IDX_W'(REG_PN):    rd_data = DATA_W'(pn_q);
            IDX_W'(REG_PM):    rd_data = DATA_W'(pm_q);
            IDX_W'(REG_RN):    rd_data = DATA_W'(rn_q);
            IDX_W'(REG_RM):    rd_data = DATA_W'(rm_q);
            IDX_W'(REG_STRAP): rd_data = DATA_W'(strap_q);
            IDX_W'(REG_STAT): begin
                rd_data[1:0]        = mode;
                rd_data[DATA_W-2]   = locked;
                rd_data[DATA_W-1]   = bad_ratio;
            end
            default: rd_data = '0;
        endcase
    end

    // R7
    wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !cfg_wd_en) |=> !locked);

endmodule

// File: tb/freq_src_sel_tb.sv
module freq_src_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] strap_in;
    logic       wd_timeout;
    logic       wr_en;
    logic [2:0] wr_idx;
    logic [7:0] wr_data;
    logic [2:0] rd_idx;
    logic [7:0] rd_data;
    logic [4:0] act_code;
    logic [7:0] act_n;
    logic [6:0] act_m;
    logic       prog_mode, freq_chg, bad_ratio, locked;

    always #4 clk = ~clk;

    freq_src_sel dut_i (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .wd_timeout(wd_timeout),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .act_code(act_code), .act_n(act_n), .act_m(act_m),
        .prog_mode(prog_mode), .freq_chg(freq_chg), .bad_ratio(bad_ratio),
        .locked(locked)
    );

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    bit done = 0;

    // reference model state: 0 capture, 1 straps, 2 register code, 3 programmable, 4 recovery
    int m_state, m_strap, m_ctrl, m_sel, m_pn, m_pm, m_rn, m_rm, m_hit;
    int m_code, m_n, m_m, m_prog, m_chg, m_bad;

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    function automatic int exp_rd(int idx);
        int mode;
        case (m_state)
            2: mode = 1;
            3: mode = 2;
            4: mode = 3;
            default: mode = 0;
        endcase
        case (idx)
            0: return m_ctrl;
            1: return m_sel;
            2: return m_pn;
            3: return m_pm;
            4: return m_rn;
            5: return m_rm;
            6: return m_strap;
            default: return m_bad * 128 + ((m_state == 4) ? 64 : 0) + mode;
        endcase
    endfunction

    task automatic model_step();
        int s, ns, c, n, m, p, ovr, pen, rsel, wden, lk, ok;
        s    = (m_state == 0) ? int'(strap_in) : m_strap;
        ovr  = m_ctrl & 1;
        pen  = (m_ctrl >> 1) & 1;
        rsel = (m_ctrl >> 2) & 1;
        wden = (m_ctrl >> 3) & 1;
        lk   = (m_state == 4);
        ok   = (m_pn > m_pm);
        if (m_state != 0 && m_state != 4 && wd_timeout && wden == 1) ns = 4;
        else if (m_state == 4 && wden == 1) ns = 4;
        else if (pen == 1 && ok == 1) ns = 3;
        else ns = (ovr == 1) ? 2 : 1;
        c = 0; n = 0; m = 0; p = 0;
        case (ns)
            1: c = s;
            2: c = m_sel;
            3: begin c = (ovr == 1) ? m_sel : s; n = m_pn; m = m_pm; p = 1; end
            default: begin
                if (rsel == 1) begin c = (ovr == 1) ? m_sel : s; n = m_rn; m = m_rm; p = 1; end
                else c = s;
            end
        endcase
        m_bad = (ns != 4 && pen == 1 && ok == 0) ? 1 : 0;
        m_chg = (m_state != 0 && ns != 4 &&
                 (c != m_code || n != m_n || m != m_m || p != m_prog || m_hit == 1)) ? 1 : 0;
        m_code = c; m_n = n; m_m = m; m_prog = p;
        m_hit = 0;
        if (wr_en) begin
            if (lk == 1) begin
                if (wr_idx == 0) m_ctrl = (m_ctrl & 7) | (int'(wr_data) & 8);
            end else begin
                case (int'(wr_idx))
                    0: m_ctrl = int'(wr_data) & 15;
                    1: begin m_sel = int'(wr_data) & 31; m_hit = 1; end
                    2: begin m_pn = int'(wr_data); m_hit = 1; end
                    3: begin m_pm = int'(wr_data) & 127; m_hit = 1; end
                    4: m_rn = int'(wr_data);
                    5: m_rm = int'(wr_data) & 127;
                    default: ;
                endcase
            end
        end
        if (m_state == 0) m_strap = int'(strap_in);
        m_state = ns;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_strap = 0; m_ctrl = 0; m_sel = 0; m_pn = 0; m_pm = 0;
            m_rn = 0; m_rm = 0; m_hit = 0; m_code = 0; m_n = 0; m_m = 0;
            m_prog = 0; m_chg = 0; m_bad = 0;
        end else begin
            model_step();
        end
        #2;
        if (freq_chg) pulses++;
        chk("R1 act_code", int'(act_code), m_code);
        chk("R2 act_n", int'(act_n), m_n);
        chk("R2 act_m", int'(act_m), m_m);
        chk("R4 prog_mode", int'(prog_mode), m_prog);
        chk("R3 bad_ratio", int'(bad_ratio), m_bad);
        chk("R5 locked", int'(locked), (m_state == 4) ? 1 : 0);
        chk("R8 freq_chg", int'(freq_chg), m_chg);
        if (rd_idx == 6) chk("R9 strap readback", int'(rd_data), exp_rd(6));
        else if (rd_idx == 7) chk("R11 status readback", int'(rd_data), exp_rd(7));
        else chk("R6 register readback", int'(rd_data), exp_rd(int'(rd_idx)));
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int idx, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic trip();
        @(negedge clk);
        wd_timeout = 1'b1;
        @(negedge clk);
        wd_timeout = 1'b0;
    endtask

    task automatic rd_chk(string req, int idx, int exp);
        @(negedge clk);
        rd_idx = 3'(idx);
        @(negedge clk);
        chk(req, int'(rd_data), exp);
    endtask

    initial begin
        rst_n = 1'b0; strap_in = 5'h13; wd_timeout = 1'b0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
        idle(3);
        chk("R10 reset code", int'(act_code), 0);
        chk("R10 reset ctrl", int'(rd_data), 0);
        chk("R10 reset lock", int'(locked), 0);
        rst_n = 1'b1;
        idle(3);
        chk("R9 strap captured", int'(act_code), 'h13);
        strap_in = 5'h04;
        idle(3);
        chk("R9 strap held", int'(act_code), 'h13);
        rd_chk("R9 strap readback", 6, 'h13);

        wr(1, 'h0A);
        idle(3);
        chk("R1 override off keeps straps", int'(act_code), 'h13);
        wr(0, 1);
        idle(3);
        chk("R1 override selects code", int'(act_code), 'h0A);
        rd_chk("R11 mode register code", 7, 1);

        wr(2, 100);
        wr(3, 50);
        wr(0, 3);
        idle(3);
        chk("R2 prog mode", int'(prog_mode), 1);
        chk("R2 N", int'(act_n), 100);
        chk("R2 M", int'(act_m), 50);
        chk("R2 ratio code from register", int'(act_code), 'h0A);
        rd_chk("R12 ctrl readback", 0, 3);
        wr(0, 2);
        idle(3);
        chk("R2 ratio code from straps", int'(act_code), 'h13);

        wr(2, 40);
        idle(3);
        chk("R3 bad flag", int'(bad_ratio), 1);
        chk("R3 fallback to table", int'(prog_mode), 0);
        chk("R4 N zero in table", int'(act_n), 0);
        wr(2, 100);
        idle(3);
        pulses = 0;
        wr(2, 100);
        idle(3);
        chk("R8 rewrite raises event", pulses, 1);

        wr(4, 120);
        wr(5, 60);
        wr(0, 'h0E);
        idle(3);
        pulses = 0;
        trip();
        idle(3);
        chk("R5 locked", int'(locked), 1);
        chk("R5 recovery N", int'(act_n), 120);
        chk("R5 recovery M", int'(act_m), 60);
        chk("R8 no event on lock", pulses, 0);
        wr(2, 77);
        wr(1, 3);
        wr(0, 'h0F);
        idle(2);
        rd_chk("R6 N write ignored", 2, 100);
        rd_chk("R6 code write ignored", 1, 'h0A);
        rd_chk("R11 mode recovery", 7, 'h43);
        pulses = 0;
        wr(0, 'h06);
        idle(3);
        chk("R6 lock released", int'(locked), 0);
        chk("R6 back to programmable", int'(act_n), 100);
        chk("R8 event on release", pulses, 1);
        rd_chk("R6 only wd bit changed", 0, 'h06);

        wr(0, 'h0A);
        idle(2);
        trip();
        idle(3);
        chk("R5 strap recovery lock", int'(locked), 1);
        chk("R5 strap recovery code", int'(act_code), 'h13);
        chk("R5 strap recovery table", int'(prog_mode), 0);
        wr(0, 'h02);
        idle(3);
        trip();
        idle(3);
        chk("R7 timeout ignored", int'(locked), 0);
        chk("R7 still programmable", int'(prog_mode), 1);

        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule